// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block keeps the interrupt side of a UART: a live status word rebuilt every cycle from the receive and transmit FIFO fill levels, a sticky interrupt word that collects those status conditions and a set of error and event pulses, and an interrupt mask. A single level interrupt line is raised whenever a sticky bit is also enabled in the mask. The FIFOs, the serial datapath and the baud timing sit outside. The block only sees the FIFO counts and the event pulses they produce.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge and reads are combinational. The mask can only be changed through a set address and a clear address. A write to the mask's own address does nothing. Sticky bits are cleared by writing ones to the sticky address. The two trigger levels that the live status compares against are writable, and both reset to 32.

Register port word addresses: 0 = mask set (write), 1 = mask clear (write), 2 = mask (read; writes ignored), 3 = sticky interrupt (read, write-one-to-clear), 4 = live status (read only), 5 = receive trigger level, 6 = transmit trigger level. Write-only and unused addresses read as zero.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live status bit 0 is 1 when the receive count is greater than or equal to the receive trigger level. Bit 1 is 1 when the receive count is 0. Bit 2 is 1 when the receive count equals the FIFO depth (64).
- R2: Live status bit 3 is 1 when the transmit count is 0. Bit 4 is 1 when it equals the FIFO depth. Bit 13 is 1 when the transmit count is greater than or equal to the transmit trigger level. All other live bits read 0.
- R3: On every clock edge out of reset, live status bits 4:0 are ORed into sticky bits 4:0. A sticky bit stays set after its condition goes away.
- R4: Live status bit 13 is ORed into sticky bit 10. Sticky bits 11 and 13 and above always read 0.
- R5: Event pulses set sticky bits on the next edge, as follows: receive overrun sets bit 5, framing error sets bit 6, parity error sets bit 7, receive timeout sets bit 8, modem status change sets bit 9, and transmit overflow sets bit 12.
- R6: A write to address 3 clears every sticky bit whose write-data bit is 1, and leaves the other sticky bits unchanged.
- R7: When a set condition and a write-one-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R8: A write to address 0 ORs the data into the mask. A write to address 1 clears the mask bits where the data is 1. A write to address 2 leaves the mask unchanged. Only mask bits 10:0 and 12 exist.
- R9: `irq` is a register that equals the OR of (mask AND sticky) as it stood one clock earlier.
- R10: During and right after reset, the mask, the sticky word and `irq` are 0, and both trigger levels are 32.
- R11: Writes to addresses 5 and 6 load the receive and transmit trigger levels from the low data bits. The live status comparisons use the new levels from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 7 | Receive FIFO fill level |
| tx_count | input | 7 | Transmit FIFO fill level |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem_chg | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | Transmit overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt output |

## Verification
The bench tests the bit remap by filling the transmit side to its trigger level and checking that sticky bit 10 sets while bit 13 stays clear. A design that copied the bit straight across would show the wrong bit. It also clears a sticky bit in the same cycle that its event pulses, and a design where the clear wins would lose the event. It writes directly to the mask address, which a naive register file would accept. It compares `irq` against a model on every clock, which catches an output that is combinational or two cycles late.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int IRQ_W   = 13;
    localparam int LIVE_W  = 14;

    // live status bit positions
    localparam int LV_RX_TRIG  = 0;
    localparam int LV_RX_EMPTY = 1;
    localparam int LV_RX_FULL  = 2;
    localparam int LV_TX_EMPTY = 3;
    localparam int LV_TX_FULL  = 4;
    localparam int LV_TX_TRIG  = 13;

    // sticky bit position for the transmit trigger
    localparam int ST_TX_TRIG  = 10;

    // implemented sticky / mask bits: 10:0 and 12
    localparam logic [IRQ_W-1:0] IMPL_MASK = 13'h17FF;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_MASK_SET = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd2;
    localparam logic [ADDR_W-1:0] A_STICKY   = 3'd3;
    localparam logic [ADDR_W-1:0] A_LIVE     = 3'd4;
    localparam logic [ADDR_W-1:0] A_RX_TRIG  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TX_TRIG  = 3'd6;

    typedef struct packed {
        logic tx_overflow;
        logic modem_chg;
        logic rx_timeout;
        logic parity_err;
        logic frame_err;
        logic rx_overrun;
    } irq_events_t;

    typedef struct packed {
        logic [IRQ_W-1:0] sticky;
        logic [IRQ_W-1:0] mask;
        logic             irq;
    } irq_core_state_t;
endpackage

// File: rtl/uart_stat_live.sv
module uart_stat_live
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic [CNT_W-1:0]  tx_trig,
    output logic [LIVE_W-1:0] live_stat
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    always_comb begin
        live_stat              = '0;
        live_stat[LV_RX_TRIG]  = (rx_count >= rx_trig);
        live_stat[LV_RX_EMPTY] = (rx_count == '0);
        live_stat[LV_RX_FULL]  = (rx_count == FULL_CNT);
        live_stat[LV_TX_EMPTY] = (tx_count == '0);
        live_stat[LV_TX_FULL]  = (tx_count == FULL_CNT);
        live_stat[LV_TX_TRIG]  = (tx_count >= tx_trig);
    end
endmodule

// File: rtl/uart_trig_regs.sv
module uart_trig_regs #(
    parameter int CNT_W      = 7,
    parameter int TRIG_RESET = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_we,
    input  logic             tx_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rx_trig,
    output logic [CNT_W-1:0] tx_trig
);
    typedef struct packed {
        logic [CNT_W-1:0] rx;
        logic [CNT_W-1:0] tx;
    } trig_state_t;

    trig_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rx_we) state_d.rx = wdata;
        if (tx_we) state_d.tx = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.rx <= CNT_W'(TRIG_RESET);
            state_q.tx <= CNT_W'(TRIG_RESET);
        end else begin
            state_q <= state_d;
        end
    end

    assign rx_trig = state_q.rx;
    assign tx_trig = state_q.tx;

    // R11: a trigger write lands on the next edge
    p_trig_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |=> (rx_trig == $past(wdata)));
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        live_lo,
    input  logic              tx_trig_hit,
    input  irq_events_t       events,
    input  logic              sticky_clr_we,
    input  logic              mask_set_we,
    input  logic              mask_clr_we,
    input  logic [IRQ_W-1:0]  wdata,
    output logic [IRQ_W-1:0]  sticky,
    output logic [IRQ_W-1:0]  mask,
    output logic              irq
);
    irq_core_state_t  state_d, state_q;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] clr_vec;

    always_comb begin
        set_vec             = '0;
        set_vec[4:0]        = live_lo;
        set_vec[5]          = events.rx_overrun;
        set_vec[6]          = events.frame_err;
        set_vec[7]          = events.parity_err;
        set_vec[8]          = events.rx_timeout;
        set_vec[9]          = events.modem_chg;
        set_vec[ST_TX_TRIG] = tx_trig_hit;
        set_vec[12]         = events.tx_overflow;

        clr_vec = sticky_clr_we ? wdata : '0;

        state_d        = state_q;
        // set has priority over write-one-to-clear
        state_d.sticky = ((state_q.sticky & ~clr_vec) | set_vec) & IMPL_MASK;
        if (mask_set_we) state_d.mask = state_d.mask | (wdata & IMPL_MASK);
        if (mask_clr_we) state_d.mask = state_d.mask & ~wdata;
        state_d.irq    = |(state_q.mask & state_q.sticky);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sticky = state_q.sticky;
    assign mask   = state_q.mask;
    assign irq    = state_q.irq;

    // R9: output is the registered masked OR
    p_irq_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(mask & sticky))));

    // R6: cleared bits without a set in the same cycle are gone
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_clr_we |=> ((sticky & $past(wdata & ~set_vec)) == '0));

    // R7: every set condition is held after the edge
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

    // R4: transmit trigger lands in sticky bit 10
    p_tx_remap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trig_hit |=> sticky[ST_TX_TRIG]);

    // R8: clear address removes the written bits
    p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr_we |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int TRIG_RESET = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_rx_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_timeout,
    input  logic              ev_modem_chg,
    input  logic              ev_tx_overflow,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  rx_trig, tx_trig;
    logic [LIVE_W-1:0] live_stat;
    logic [IRQ_W-1:0]  sticky, mask;
    irq_events_t       events;
    logic              we_mset, we_mclr, we_sticky, we_rtrig, we_ttrig;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:IRQ_W];

    assign we_mset   = reg_wr && (reg_addr == A_MASK_SET);
    assign we_mclr   = reg_wr && (reg_addr == A_MASK_CLR);
    assign we_sticky = reg_wr && (reg_addr == A_STICKY);
    assign we_rtrig  = reg_wr && (reg_addr == A_RX_TRIG);
    assign we_ttrig  = reg_wr && (reg_addr == A_TX_TRIG);

    assign events = '{tx_overflow: ev_tx_overflow, modem_chg: ev_modem_chg,
                      rx_timeout: ev_rx_timeout, parity_err: ev_parity_err,
                      frame_err: ev_frame_err, rx_overrun: ev_rx_overrun};

    uart_trig_regs #(.CNT_W(CNT_W), .TRIG_RESET(TRIG_RESET)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_we   (we_rtrig),
        .tx_we   (we_ttrig),
        .wdata   (reg_wdata[CNT_W-1:0]),
        .rx_trig (rx_trig),
        .tx_trig (tx_trig)
    );

    uart_stat_live #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
        .rx_count  (rx_count),
        .tx_count  (tx_count),
        .rx_trig   (rx_trig),
        .tx_trig   (tx_trig),
        .live_stat (live_stat)
    );

    uart_irq_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .live_lo       (live_stat[4:0]),
        .tx_trig_hit   (live_stat[LV_TX_TRIG]),
        .events        (events),
        .sticky_clr_we (we_sticky),
        .mask_set_we   (we_mset),
        .mask_clr_we   (we_mclr),
        .wdata         (reg_wdata[IRQ_W-1:0]),
        .sticky        (sticky),
        .mask          (mask),
        .irq           (irq)
    );

    always_comb begin
        unique case (reg_addr)
            A_MASK:    reg_rdata = DATA_W'(mask);
            A_STICKY:  reg_rdata = DATA_W'(sticky);
            A_LIVE:    reg_rdata = DATA_W'(live_stat);
            A_RX_TRIG: reg_rdata = DATA_W'(rx_trig);
            A_TX_TRIG: reg_rdata = DATA_W'(tx_trig);
            default:   reg_rdata = '0;
        endcase
    end

    // R8: a direct mask write changes nothing
    p_mask_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK) |=> $stable(mask));

    // R1: receive FIFO cannot be empty and full together
    p_rx_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(live_stat[LV_RX_EMPTY] && live_stat[LV_RX_FULL]));

    // R5: an overrun pulse is recorded on the next edge
    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> sticky[5]);
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rx_count = '0, tx_count = '0;
    logic        ev_ovr = 0, ev_frm = 0, ev_par = 0, ev_to = 0, ev_mod = 0, ev_txo = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [12:0] m_sticky, m_mask;
    logic        m_irq;
    logic [6:0]  m_rt, m_tt;
    localparam logic [12:0] IMPL = 13'h17FF;

    always #5 clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .ev_rx_overrun(ev_ovr), .ev_frame_err(ev_frm), .ev_parity_err(ev_par),
        .ev_rx_timeout(ev_to), .ev_modem_chg(ev_mod), .ev_tx_overflow(ev_txo),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [13:0] f_live(input int rx, input int tx, input int rt, input int tt);
        logic [13:0] v = '0;
        v[0]  = (rx >= rt);
        v[1]  = (rx == 0);
        v[2]  = (rx == 64);
        v[3]  = (tx == 0);
        v[4]  = (tx == 64);
        v[13] = (tx >= tt);
        return v;
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a);
        case (a)
            3'd2: return {19'd0, m_mask};
            3'd3: return {19'd0, m_sticky};
            3'd4: return {18'd0, f_live(rx_count, tx_count, m_rt, m_tt)};
            3'd5: return {25'd0, m_rt};
            3'd6: return {25'd0, m_tt};
            default: return 32'd0;
        endcase
    endfunction

    // reference model, advanced on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sticky = '0; m_mask = '0; m_irq = 0; m_rt = 7'd32; m_tt = 7'd32;
        end else begin
            logic [13:0] lv;
            logic [12:0] setv, clrv;
            logic        nirq;
            lv   = f_live(rx_count, tx_count, m_rt, m_tt);
            setv = {ev_txo, 1'b0, lv[13], ev_mod, ev_to, ev_par, ev_frm, ev_ovr, lv[4:0]};
            clrv = (reg_wr && reg_addr == 3'd3) ? reg_wdata[12:0] : '0;
            nirq = |(m_mask & m_sticky);
            m_sticky = ((m_sticky & ~clrv) | setv) & IMPL;
            if (reg_wr && reg_addr == 3'd0) m_mask = m_mask | (reg_wdata[12:0] & IMPL);
            if (reg_wr && reg_addr == 3'd1) m_mask = m_mask & ~reg_wdata[12:0];
            if (reg_wr && reg_addr == 3'd5) m_rt = reg_wdata[6:0];
            if (reg_wr && reg_addr == 3'd6) m_tt = reg_wdata[6:0];
            m_irq = nirq;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        reg_wr = 0; reg_addr = a;
        #1;
        check(tag, reg_rdata, f_read(a));
    endtask

    // one clock with the given write; irq compared to the model afterwards
    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0;
        {ev_ovr, ev_frm, ev_par, ev_to, ev_mod, ev_txo} = '0;
        #1;
        check("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10: exact reset values
        check("R10 mask", f_read(3'd2), 0); rd("R10 mask", 3'd2);
        rd("R10 sticky", 3'd3); check("R10 sticky0", reg_rdata, 0);
        rd("R10 rtrig", 3'd5);  check("R10 rtrig32", reg_rdata, 32);
        rd("R10 ttrig", 3'd6);  check("R10 ttrig32", reg_rdata, 32);
        check("R10 irq", {31'd0, irq}, 0);

        // R1 R2 R3: idle empty FIFOs latch empty bits
        step(0, 0, 0);
        rd("R1 live empty", 3'd4);
        rd("R3 sticky empty", 3'd3);
        check("R3 sticky bits1,3", reg_rdata, 32'h0000_000A);

        // R6: clear all with no condition active
        rx_count = 5; tx_count = 5;
        step(1, 3'd3, 32'hFFFF_FFFF);
        rd("R6 sticky cleared", 3'd3);
        check("R6 sticky zero", reg_rdata, 0);

        // R1: trigger and full
        rx_count = 40; step(0, 0, 0); rd("R1 rx trig", 3'd4); rd("R1 sticky", 3'd3);
        rx_count = 64; step(0, 0, 0); rd("R1 rx full", 3'd4);
        // R2 R4: tx full and trigger, remap to bit 10
        tx_count = 64; step(0, 0, 0); rd("R2 tx full trig", 3'd4);
        rd("R4 sticky remap", 3'd3);
        check("R4 bit10 set bit13 clear", reg_rdata & 32'h0000_2400, 32'h0000_0400);
        // R3: conditions gone, sticky holds
        rx_count = 5; tx_count = 5; step(0, 0, 0);
        rd("R3 sticky holds", 3'd3);
        check("R3 hold value", reg_rdata, 32'h0000_0415);

        // R5: each event
        step(1, 3'd3, 32'h1FFF);
        ev_ovr = 1; step(0, 0, 0); rd("R5 overrun", 3'd3);
        ev_frm = 1; step(0, 0, 0); rd("R5 frame", 3'd3);
        ev_par = 1; step(0, 0, 0); rd("R5 parity", 3'd3);
        ev_to  = 1; step(0, 0, 0); rd("R5 timeout", 3'd3);
        ev_mod = 1; step(0, 0, 0); rd("R5 modem", 3'd3);
        ev_txo = 1; step(0, 0, 0); rd("R5 txovf", 3'd3);
        check("R5 all events", reg_rdata, 32'h0000_13E0);

        // R6: partial clear
        step(1, 3'd3, 32'h0000_00A0); rd("R6 partial", 3'd3);
        check("R6 partial value", reg_rdata, 32'h0000_1340);

        // R7: set and clear collide on bit 7
        ev_par = 1; step(1, 3'd3, 32'h0000_0080); rd("R7 set wins", 3'd3);
        check("R7 bit7", reg_rdata & 32'h80, 32'h80);

        // R8 R9: mask control and irq timing
        step(1, 3'd0, 32'h0000_0040); rd("R8 mask set", 3'd2);
        step(0, 0, 0); check("R9 irq high", {31'd0, irq}, 1);
        step(1, 3'd2, 32'h0000_1FFF); rd("R8 direct ignored", 3'd2);
        check("R8 mask value", reg_rdata, 32'h40);
        step(1, 3'd0, 32'hFFFF_FFFF); rd("R8 impl bits", 3'd2);
        check("R8 impl value", reg_rdata, 32'h17FF);
        step(1, 3'd1, 32'h0000_17FF); rd("R8 mask clr", 3'd2);
        step(0, 0, 0); check("R9 irq low", {31'd0, irq}, 0);
        step(1, 3'd0, 32'h0000_0002); step(0, 0, 0);
        rd("R9 mask empty only", 3'd2);

        // R11: trigger levels
        step(1, 3'd5, 32'h0000_0000); rd("R11 rtrig", 3'd5);
        rd("R11 live rx trig", 3'd4);
        check("R11 bit0", reg_rdata & 1, 1);
        step(1, 3'd6, 32'h0000_000A); rd("R11 ttrig", 3'd6);
        tx_count = 9;  step(0, 0, 0); rd("R11 below ttrig", 3'd4);
        tx_count = 10; step(0, 0, 0); rd("R11 at ttrig", 3'd4);
        rd("R4 sticky after ttrig", 3'd3);
        rx_count = 0; tx_count = 0;
        step(1, 3'd0, 32'h1FFF); step(0, 0, 0); step(0, 0, 0);
        rd("R9 final mask", 3'd2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule